// File: doc/BRIEF.md
# Paired Transmit/Receive FIFO with Wrapping Level Status

This block holds two identical first-in first-out queues for a serial controller. One carries words toward the bus engine and the other carries received words back toward software. Each queue stores up to eight 9-bit words. Each queue reports a 3-bit level, a full flag and a half flag. The level field is one bit narrower than the count it reports, so a queue holding eight words reads a level of zero. Software has to look at the full flag to tell a full queue from an empty one.

Each queue has a write strobe with data and a read strobe. The oldest stored word is always visible on the read data port, and a read strobe retires it. A synchronous soft-reset input empties both queues in a single cycle. If the soft reset arrives while the receive queue still holds words, the block raises a busy error for one cycle. The flush goes ahead anyway.

Top module: `ring_fifo_pair`

## Requirements
- R1: After `rst_n` is released, both queues are empty: level 0, full 0 and half 0 on both sides, and `busy_err` is 0.
- R2: Words leave each queue in the order they were written. `*_rd_data` always shows the oldest stored word, and a read strobe accepted at a clock edge advances it to the next word.
- R3: A write strobe while a queue holds 8 words is ignored, with or without a read strobe. The stored words, the level and the flags do not change because of it.
- R4: A read strobe while a queue is empty is ignored. The level stays 0, and a later write followed by a read returns the written word.
- R5: `*_level` equals the number of stored words modulo 8. It reads 0 when the queue holds 8 words.
- R6: `*_full` is 1 exactly when the queue holds 8 words.
- R7: `*_half` is 1 exactly when the queue holds 4 or more words.
- R8: A read and a write in the same cycle on a queue holding 1 to 7 words leave its level unchanged and keep the word order. On a full queue only the read takes effect. On an empty queue only the write takes effect.
- R9: When `soft_rst` is sampled high, both queues are empty after that edge. Any write or read strobed in the same cycle is ignored.
- R10: `busy_err` is 1 for exactly the cycle after an edge at which `soft_rst` was high while the receive queue held at least one word. It is 0 after every other edge. The contents of the transmit queue have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both queues |
| tx_wr_en | input | 1 | Transmit queue write strobe |
| tx_wr_data | input | 9 | Transmit queue write word |
| tx_rd_en | input | 1 | Transmit queue read strobe |
| tx_rd_data | output | 9 | Oldest transmit word |
| tx_level | output | 3 | Transmit word count modulo 8 |
| tx_full | output | 1 | Transmit queue holds 8 words |
| tx_half | output | 1 | Transmit queue holds 4 or more words |
| rx_wr_en | input | 1 | Receive queue write strobe |
| rx_wr_data | input | 9 | Receive queue write word |
| rx_rd_en | input | 1 | Receive queue read strobe |
| rx_rd_data | output | 9 | Oldest receive word |
| rx_level | output | 3 | Receive word count modulo 8 |
| rx_full | output | 1 | Receive queue holds 8 words |
| rx_half | output | 1 | Receive queue holds 4 or more words |
| busy_err | output | 1 | Flush requested while the receive queue was not empty |

## Verification
The bench builds the block with its default parameters: 8 entries of 9 bits. With these values both queues reach the point where the level wraps to 0 at full occupancy, and the half threshold falls at 4. A few hundred random cycles are enough to fill and drain each queue repeatedly. Directed sequences push both queues to exactly 8 words, overflow and underflow them, and issue soft resets with the receive queue empty, non-empty and full. The soft resets are also issued in cycles that carry their own write and read strobes.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    localparam int unsigned RFP_DEPTH = 8;
    localparam int unsigned RFP_WIDTH = 9;
    localparam int unsigned RFP_SIDES = 2;
    localparam int unsigned SIDE_TX   = 0;
    localparam int unsigned SIDE_RX   = 1;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;
endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import rfp_pkg::*;
#(
    parameter int unsigned DEPTH = RFP_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       wr_req,
    input  logic                       rd_req,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       wr_fire
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } ctrl_t;

    ctrl_t    st_d, st_q;
    fifo_op_e op;
    logic     is_full, is_empty, wr_ok, rd_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.count == CNT_FULL);
        is_empty = (st_q.count == '0);
        wr_ok    = wr_req && !is_full  && !flush;
        rd_ok    = rd_req && !is_empty && !flush;
        op       = fifo_op_e'({wr_ok, rd_ok});
        if (flush) begin
            st_d = '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
                    st_d.count  = st_q.count + 1'b1;
                end
                OP_POP: begin
                    st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
                    st_d.count  = st_q.count - 1'b1;
                end
                OP_BOTH: begin
                    st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
                    st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr  = st_q.wr_ptr;
    assign rd_ptr  = st_q.rd_ptr;
    assign count   = st_q.count;
    assign wr_fire = wr_ok;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_FULL) else $error("count above depth"); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_req && !rd_req && !flush) |=> ($stable(st_q.count) && $stable(st_q.wr_ptr)))
        else $error("write accepted while full"); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_req && !wr_req && !flush) |=> ($stable(st_q.count) && $stable(st_q.rd_ptr)))
        else $error("read accepted while empty"); // R4
    AST_SAME_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && rd_req && !is_full && !is_empty && !flush) |=> $stable(st_q.count))
        else $error("level moved on read+write"); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0 && st_q.wr_ptr == '0 && st_q.rd_ptr == '0))
        else $error("flush left state"); // R9
endmodule

// File: rtl/fifo_store.sv
module fifo_store
    import rfp_pkg::*;
#(
    parameter int unsigned DEPTH = RFP_DEPTH,
    parameter int unsigned WIDTH = RFP_WIDTH
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_data
);
    localparam int unsigned PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] entry_d [DEPTH];
    logic [WIDTH-1:0] entry_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_comb begin
            entry_d[e] = entry_q[e];
            if (wr_en && (wr_addr == PTR_W'(e))) entry_d[e] = wr_data;
        end
        always_ff @(posedge clk) begin
            entry_q[e] <= entry_d[e];
        end
    end

    assign rd_data = entry_q[rd_addr];
endmodule

// File: rtl/level_flags.sv
module level_flags
    import rfp_pkg::*;
#(
    parameter int unsigned DEPTH = RFP_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH):0]   count,
    output logic [$clog2(DEPTH)-1:0] level,
    output logic                     full,
    output logic                     half
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);

    always_comb begin
        full  = (count == CNT_FULL);
        half  = (count >= CNT_HALF);
        level = full ? '0 : count[PTR_W-1:0];
    end

    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half) else $error("full without half"); // R7
endmodule

// File: rtl/ring_fifo_pair.sv
module ring_fifo_pair
    import rfp_pkg::*;
#(
    parameter int unsigned DEPTH = RFP_DEPTH,
    parameter int unsigned WIDTH = RFP_WIDTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     soft_rst,
    input  logic                     tx_wr_en,
    input  logic [WIDTH-1:0]         tx_wr_data,
    input  logic                     tx_rd_en,
    output logic [WIDTH-1:0]         tx_rd_data,
    output logic [$clog2(DEPTH)-1:0] tx_level,
    output logic                     tx_full,
    output logic                     tx_half,
    input  logic                     rx_wr_en,
    input  logic [WIDTH-1:0]         rx_wr_data,
    input  logic                     rx_rd_en,
    output logic [WIDTH-1:0]         rx_rd_data,
    output logic [$clog2(DEPTH)-1:0] rx_level,
    output logic                     rx_full,
    output logic                     rx_half,
    output logic                     busy_err
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    typedef struct packed {
        logic busy_err;
    } guard_t;

    logic             s_wr_en   [RFP_SIDES];
    logic             s_rd_en   [RFP_SIDES];
    logic [WIDTH-1:0] s_wr_data [RFP_SIDES];
    logic [WIDTH-1:0] s_rd_data [RFP_SIDES];
    logic [PTR_W-1:0] s_wr_ptr  [RFP_SIDES];
    logic [PTR_W-1:0] s_rd_ptr  [RFP_SIDES];
    logic [CNT_W-1:0] s_count   [RFP_SIDES];
    logic             s_fire    [RFP_SIDES];
    logic [PTR_W-1:0] s_level   [RFP_SIDES];
    logic             s_full    [RFP_SIDES];
    logic             s_half    [RFP_SIDES];

    assign s_wr_en[SIDE_TX]   = tx_wr_en;
    assign s_rd_en[SIDE_TX]   = tx_rd_en;
    assign s_wr_data[SIDE_TX] = tx_wr_data;
    assign s_wr_en[SIDE_RX]   = rx_wr_en;
    assign s_rd_en[SIDE_RX]   = rx_rd_en;
    assign s_wr_data[SIDE_RX] = rx_wr_data;

    for (genvar s = 0; s < RFP_SIDES; s++) begin : g_side
        fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (soft_rst),
            .wr_req  (s_wr_en[s]),
            .rd_req  (s_rd_en[s]),
            .wr_ptr  (s_wr_ptr[s]),
            .rd_ptr  (s_rd_ptr[s]),
            .count   (s_count[s]),
            .wr_fire (s_fire[s])
        );
        fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
            .clk     (clk),
            .wr_en   (s_fire[s]),
            .wr_addr (s_wr_ptr[s]),
            .wr_data (s_wr_data[s]),
            .rd_addr (s_rd_ptr[s]),
            .rd_data (s_rd_data[s])
        );
        level_flags #(.DEPTH(DEPTH)) u_flags (
            .clk   (clk),
            .rst_n (rst_n),
            .count (s_count[s]),
            .level (s_level[s]),
            .full  (s_full[s]),
            .half  (s_half[s])
        );
    end

    assign tx_rd_data = s_rd_data[SIDE_TX];
    assign tx_level   = s_level[SIDE_TX];
    assign tx_full    = s_full[SIDE_TX];
    assign tx_half    = s_half[SIDE_TX];
    assign rx_rd_data = s_rd_data[SIDE_RX];
    assign rx_level   = s_level[SIDE_RX];
    assign rx_full    = s_full[SIDE_RX];
    assign rx_half    = s_half[SIDE_RX];

    guard_t g_d, g_q;

    always_comb begin
        g_d          = g_q;
        g_d.busy_err = soft_rst && (s_count[SIDE_RX] != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign busy_err = g_q.busy_err;

    AST_BUSY_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && (rx_full || rx_level != '0)) |=> busy_err)
        else $error("busy error missing"); // R10
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst || (!rx_full && rx_level == '0)) |=> !busy_err)
        else $error("spurious busy error"); // R10
    AST_FLUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_full && !rx_full && tx_level == '0 && rx_level == '0))
        else $error("flags after flush"); // R9
endmodule

// File: tb/ring_fifo_pair_tb_top.sv
module ring_fifo_pair_tb_top;
    localparam int DEPTH = 8;
    localparam int WIDTH = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic tx_wr_en = 1'b0, tx_rd_en = 1'b0, rx_wr_en = 1'b0, rx_rd_en = 1'b0;
    logic [WIDTH-1:0] tx_wr_data = '0, rx_wr_data = '0;
    logic [WIDTH-1:0] tx_rd_data, rx_rd_data;
    logic [2:0] tx_level, rx_level;
    logic tx_full, tx_half, rx_full, rx_half, busy_err;

    always #2.5 clk = ~clk;

    ring_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_rd_en(tx_rd_en),
        .tx_rd_data(tx_rd_data), .tx_level(tx_level), .tx_full(tx_full), .tx_half(tx_half),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data), .rx_rd_en(rx_rd_en),
        .rx_rd_data(rx_rd_data), .rx_level(rx_level), .rx_full(rx_full), .rx_half(rx_half),
        .busy_err(busy_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [WIDTH-1:0] q_tx[$];
    logic [WIDTH-1:0] q_rx[$];
    logic exp_busy = 1'b0;

    function automatic logic [2:0] exp_level(int n);
        return 3'(n % DEPTH);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_side(string req, string nm, logic [2:0] lvl, logic fl, logic hf,
                              logic [WIDTH-1:0] head, int n, logic [WIDTH-1:0] exp_head);
        chk(lvl == exp_level(n), req, {nm, " level (R5)"}, lvl, exp_level(n));
        chk(fl == (n == DEPTH), req, {nm, " full (R6)"}, fl, (n == DEPTH));
        chk(hf == (n >= DEPTH / 2), req, {nm, " half (R7)"}, hf, (n >= DEPTH / 2));
        if (n > 0) chk(head == exp_head, req, {nm, " head (R2)"}, head, exp_head);
    endtask

    task automatic check_all(string req);
        check_side(req, "tx", tx_level, tx_full, tx_half, tx_rd_data, q_tx.size(),
                   (q_tx.size() > 0) ? q_tx[0] : '0);
        check_side(req, "rx", rx_level, rx_full, rx_half, rx_rd_data, q_rx.size(),
                   (q_rx.size() > 0) ? q_rx[0] : '0);
        chk(busy_err == exp_busy, req, "busy_err (R10)", busy_err, exp_busy);
    endtask

    task automatic model_side(ref logic [WIDTH-1:0] q[$], input logic w, input logic r,
                              input logic [WIDTH-1:0] d);
        bit full_now = (q.size() == DEPTH);
        bit empty_now = (q.size() == 0);
        if (r && !empty_now) void'(q.pop_front());
        if (w && !full_now) q.push_back(d);
    endtask

    // Applies one cycle of stimulus (called at a negedge), then checks at the next negedge.
    task automatic step(logic tw, logic tr, logic rw, logic rr, logic sr, string req);
        tx_wr_en = tw; tx_rd_en = tr; rx_wr_en = rw; rx_rd_en = rr; soft_rst = sr;
        tx_wr_data = WIDTH'($urandom);
        rx_wr_data = WIDTH'($urandom);
        @(posedge clk);
        @(negedge clk);
        exp_busy = sr && (q_rx.size() != 0);
        if (sr) begin
            q_tx.delete();
            q_rx.delete();
        end else begin
            model_side(q_tx, tw, tr, tx_wr_data);
            model_side(q_rx, rw, rr, rx_wr_data);
        end
        tx_wr_en = 0; tx_rd_en = 0; rx_wr_en = 0; rx_rd_en = 0; soft_rst = 0;
        check_all(req);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R4: reads on empty queues
        step(0, 1, 0, 1, 0, "R4");
        step(1, 0, 1, 0, 0, "R4");
        step(0, 1, 0, 1, 0, "R4");
        // R6/R5: fill both to 8, level wraps to 0
        for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 0, 0, "R6");
        // R3: overflow ignored, also with read on full (only read counts)
        step(1, 0, 1, 0, 0, "R3");
        step(1, 1, 1, 1, 0, "R8");
        step(1, 0, 1, 0, 0, "R3");
        // R8: read+write with 1..7 entries
        for (int i = 0; i < 6; i++) step(0, 1, 0, 1, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, 0, "R8");
        // R10: soft reset with rx non-empty, strobes same cycle ignored (R9)
        step(1, 1, 1, 1, 1, "R9");
        step(0, 0, 0, 0, 0, "R10");
        // R10: tx non-empty, rx empty -> no error
        step(1, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 1, "R10");
        // empty-queue read+write: only write
        step(1, 1, 1, 1, 0, "R8");
        // fill rx to full, then soft reset
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0, "R6");
        step(0, 0, 0, 0, 1, "R10");

        // random phase
        for (int c = 0; c < 3000; c++) begin
            int bias = (c / 300) % 3;
            logic tw = ($urandom % 4) < ((bias == 0) ? 3 : (bias == 1) ? 2 : 1);
            logic tr = ($urandom % 4) < ((bias == 0) ? 1 : (bias == 1) ? 2 : 3);
            logic rw = ($urandom % 4) < ((bias == 2) ? 1 : 3 - bias);
            logic rr = ($urandom % 4) < (bias + 1);
            logic sr = ($urandom % 97) == 0;
            step(tw, tr, rw, rr, sr, "R2");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule